// File: doc/BRIEF.md
# Shared-Bus Converter Bank Readout Sequencer

This block reads a bank of parallel-output analog-to-digital converters that all drive one common data bus. It divides the system clock to produce the shared conversion clock. In every conversion period it grants the bus to each converter in turn through that converter's own active-low output-enable line. It registers the bus one system cycle after each grant, because a converter puts its word on the bus with a delay. After the last converter has been read, the samples are published together as one frame, marked by a single-cycle valid pulse.

A period lasts `DIV` system cycles, which is 25 by default. The conversion clock is high for the first `DIV/2` cycles of the period and low for the rest. The read sequence starts on the first low cycle. Channel `k` is granted in the (k+1)-th low cycle, and its word is registered at the end of the cycle after that. With eight channels, the whole sequence takes ten cycles, from the first grant to the valid pulse. An enable input gates the sequence. If enable drops while a frame is being collected, that frame is dropped.

Top module: `adc_bank_reader`

## Requirements
- R1: The divider restarts at phase 0 when reset is released. `smp_clk_o` is high in phases 0..`DIV/2`-1 and low in phases `DIV/2`..`DIV`-1. The period is exactly `DIV` cycles, and the divider keeps running whether or not enable is high.
- R2: Every bit of `adc_oe_n_o` is active low. No more than one bit is low in any cycle.
- R3: In a period that is being read, bit `k` of `adc_oe_n_o` is low only in phase `DIV/2`+k, which is always a cycle in which `smp_clk_o` is low. Channels are granted in ascending order, one per cycle.
- R4: The bus value in the cycle right after channel `k`'s grant becomes field `k` of `frame_o`, at bits [k*DW +: DW].
- R5: `frame_valid_o` is high for exactly one cycle, in phase `DIV/2`+NCH+1 of a completed period. In that same cycle, `frame_o` shows that period's samples.
- R6: `frame_o` changes only in a cycle where `frame_valid_o` is high. The bus value in any cycle that is not a capture cycle has no effect on it.
- R7: While `rst_n` is low at a clock edge, the next cycle shows all enables high, `frame_valid_o` low, `frame_o` zero and `smp_clk_o` high.
- R8: If `en_i` is low at a clock edge, every bit of `adc_oe_n_o` is high in the following cycle.
- R9: A frame is published only if `en_i` is high at every edge from the end of phase `DIV/2`-1 to the end of phase `DIV/2`+NCH. If it is low at any of those edges, the rest of that period's grants are withheld and no valid pulse is produced.
- R10: If `en_i` rises partway through a read sequence, no grant is issued until the next period's sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enables the read sequence |
| adc_bus_i | input | DW | Shared converter data bus |
| smp_clk_o | output | 1 | Divided conversion clock |
| adc_oe_n_o | output | NCH | Per-converter active-low output enables |
| frame_valid_o | output | 1 | One-cycle pulse when a new frame is published |
| frame_o | output | NCH*DW | Channel k occupies bits [k*DW +: DW] |

## Verification
A behavioural model follows the phase, the grants, the captured bus words and the published frame on every cycle. Outside the capture cycles, the bus carries random values. A design that samples the bus in the grant cycle instead of the cycle after would therefore publish noise. Enable is dropped at several points: in the middle of a sequence, on the very last capture cycle, and on the edge just before the sequence would start. A design that publishes a partial frame, or that checks enable only at the start, produces a valid pulse the model does not expect. Enable is also raised in the middle of a sequence and held off for whole periods. This catches a design that resumes granting in the middle of a period, or that stops the conversion clock while disabled.

// File: rtl/adc_rd_pkg.sv
// Package: adc_rd_pkg
// Holds the default geometry shared by the readout sequencer modules.
// Assumes the read sequence plus one publish cycle fits in the low half.
package adc_rd_pkg;
    localparam int DEF_DIV = 25;   // system cycles per conversion period
    localparam int DEF_NCH = 8;    // converters on the shared bus
    localparam int DEF_DW  = 14;   // bus width in bits
endpackage

// File: rtl/adc_clk_div.sv
// Module: adc_clk_div
// Free-running phase counter that produces the conversion clock.
// Assumes DIV >= 2; the clock is high for HI_CYC phases, then low.
module adc_clk_div #(
    parameter int DIV    = 25,
    parameter int HI_CYC = 12,
    parameter int PW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_o,
    output logic [PW-1:0] phase_nxt_o,
    output logic          smp_clk_o
);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] HI_P = PW'(HI_CYC);

    logic [PW-1:0] phase_q;
    logic          smp_q;

    // Next phase: wraps from the last phase back to zero.
    always_comb begin
        phase_nxt_o = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    // Phase counter and registered clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            smp_q   <= 1'b1;
        end else begin
            phase_q <= phase_nxt_o;
            smp_q   <= (phase_nxt_o < HI_P);
        end
    end

    assign phase_o   = phase_q;
    assign smp_clk_o = smp_q;

    // After the final phase, the clock must be high again (period restart).
    assert_period_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == LAST) |=> (smp_clk_o && phase_o == '0));
endmodule

// File: rtl/adc_oe_seq.sv
// Module: adc_oe_seq
// Issues the one-hot, active-low bus grants and the capture strobes.
// Assumes START+NCH < DIV so the whole sequence fits in one period.
module adc_oe_seq #(
    parameter int NCH   = 8,
    parameter int PW    = 5,
    parameter int START = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [PW-1:0]  phase_i,
    input  logic [PW-1:0]  phase_nxt_i,
    output logic [NCH-1:0] oe_n_o,
    output logic [NCH-1:0] cap_o,
    output logic           done_o
);
    localparam logic [PW-1:0] START_P = PW'(START);

    logic           good_q;
    logic           good_d;
    logic [NCH-1:0] oe_n_q;

    // Frame health: re-armed at sequence start, cleared by any enable drop.
    always_comb begin
        good_d = (phase_nxt_i == START_P) ? en_i : (good_q & en_i);
    end

    // Frame-health register.
    always_ff @(posedge clk) begin
        if (!rst_n) good_q <= 1'b0;
        else        good_q <= good_d;
    end

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_ch
            // Registered grant for channel k, low only in its own phase.
            always_ff @(posedge clk) begin
                if (!rst_n) oe_n_q[k] <= 1'b1;
                else        oe_n_q[k] <= ~(good_d && (phase_nxt_i == PW'(START + k)));
            end
            // Capture strobe one cycle after channel k's grant.
            assign cap_o[k] = good_q && (phase_i == PW'(START + k + 1));
        end
    endgenerate

    assign oe_n_o = oe_n_q;
    assign done_o = cap_o[NCH-1] & en_i;

    assert_oe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~oe_n_o));
    assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (&oe_n_o));
endmodule

// File: rtl/adc_frame_cap.sv
// Module: adc_frame_cap
// Collects one bus word per capture strobe and publishes the frame.
// Assumes strobes are one-hot and that done coincides with the last strobe.
module adc_frame_cap #(
    parameter int NCH = 8,
    parameter int DW  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     bus_i,
    input  logic [NCH-1:0]    cap_i,
    input  logic              done_i,
    output logic [NCH*DW-1:0] frame_o,
    output logic              valid_o
);
    logic [DW-1:0]     shadow_q [NCH-1];
    logic [NCH*DW-1:0] frame_q;
    logic              valid_q;

    genvar k;
    generate
        for (k = 0; k < NCH - 1; k++) begin : g_shadow
            // Holds channel k's word until the frame is published.
            always_ff @(posedge clk) begin
                if (!rst_n)        shadow_q[k] <= '0;
                else if (cap_i[k]) shadow_q[k] <= bus_i;
            end
            // Published copy of channel k.
            always_ff @(posedge clk) begin
                if (!rst_n)      frame_q[k*DW +: DW] <= '0;
                else if (done_i) frame_q[k*DW +: DW] <= shadow_q[k];
            end
        end
    endgenerate

    // Last channel goes straight from the bus to the published frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      frame_q[(NCH-1)*DW +: DW] <= '0;
        else if (done_i) frame_q[(NCH-1)*DW +: DW] <= bus_i;
    end

    // One-cycle publish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= done_i;
    end

    assign frame_o = frame_q;
    assign valid_o = valid_q;

    assert_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(frame_o));
endmodule

// File: rtl/adc_bank_reader.sv
// Module: adc_bank_reader
// Top: divides the clock, sequences grants on the shared bus, builds frames.
// Assumes DIV/2 + NCH + 1 < DIV so publishing happens within the period.
module adc_bank_reader #(
    parameter int DIV = adc_rd_pkg::DEF_DIV,
    parameter int NCH = adc_rd_pkg::DEF_NCH,
    parameter int DW  = adc_rd_pkg::DEF_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DW-1:0]     adc_bus_i,
    output logic              smp_clk_o,
    output logic [NCH-1:0]    adc_oe_n_o,
    output logic              frame_valid_o,
    output logic [NCH*DW-1:0] frame_o
);
    localparam int HI_CYC = DIV / 2;
    localparam int PW     = $clog2(DIV);

    logic [PW-1:0]  phase;
    logic [PW-1:0]  phase_nxt;
    logic [NCH-1:0] cap;
    logic           done;

    adc_clk_div #(.DIV(DIV), .HI_CYC(HI_CYC), .PW(PW)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_o     (phase),
        .phase_nxt_o (phase_nxt),
        .smp_clk_o   (smp_clk_o)
    );

    adc_oe_seq #(.NCH(NCH), .PW(PW), .START(HI_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .phase_i     (phase),
        .phase_nxt_i (phase_nxt),
        .oe_n_o      (adc_oe_n_o),
        .cap_o       (cap),
        .done_o      (done)
    );

    adc_frame_cap #(.NCH(NCH), .DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_i   (adc_bus_i),
        .cap_i   (cap),
        .done_i  (done),
        .frame_o (frame_o),
        .valid_o (frame_valid_o)
    );

    assert_grant_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&adc_oe_n_o) |-> !smp_clk_o);
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);
endmodule

// File: tb/adc_bank_reader_test.sv
// Bench: behavioural per-cycle model of the readout sequencer, compared on every cycle.
module adc_bank_reader_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 25;
    localparam int NCH = 8;
    localparam int DW  = 14;
    localparam int HI  = DIV / 2;
    localparam int NCYC = DIV * 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              en;
    logic [DW-1:0]     bus;
    logic              smp_clk;
    logic [NCH-1:0]    oe_n;
    logic              fvalid;
    logic [NCH*DW-1:0] frame;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_bank_reader #(.DIV(DIV), .NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .adc_bus_i(bus),
        .smp_clk_o(smp_clk), .adc_oe_n_o(oe_n),
        .frame_valid_o(fvalid), .frame_o(frame)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Converter word for channel k in period p.
    function automatic int word_of(input int k, input int p);
        return (p * 37 + k * 101 + 5) & ((1 << DW) - 1);
    endfunction

    // Enable schedule by cycle index since reset release.
    function automatic bit en_for(input int c);
        int p = c / DIV;
        int q = c % DIV;
        if (p == 6 && q == HI + 3) return 0;          // drop mid sequence (R9)
        if (p >= 8 && p <= 10) return 0;              // off whole periods (R1, R8)
        if (p == 11 && q < HI + 2) return 0;          // rise mid sequence (R10)
        if (p == 13 && q == HI + NCH) return 0;       // drop on last capture (R9)
        if (p == 15 && q == HI - 1) return 0;         // drop on edge before start (R9)
        return 1;
    endfunction

    // Reference model state.
    int pos;
    bit good;
    logic [NCH-1:0] m_oe;
    bit m_smp;
    bit m_valid;
    int m_frame [NCH];
    int q_words [$];

    task automatic model_reset();
        pos = 0; good = 0; m_oe = '1; m_smp = 1; m_valid = 0;
        foreach (m_frame[i]) m_frame[i] = 0;
        q_words.delete();
    endtask

    task automatic model_step(input bit e, input int b);
        int nxt;
        if (pos == HI) q_words.delete();
        if (good && pos >= HI + 1 && pos <= HI + NCH) q_words.push_back(b);
        m_valid = (pos == HI + NCH) && good && e;
        if (m_valid) foreach (m_frame[i]) m_frame[i] = q_words[i];
        nxt = (pos + 1) % DIV;
        good = (nxt == HI) ? e : (good && e);
        m_oe = '1;
        if (good && nxt >= HI && nxt < HI + NCH) m_oe[nxt - HI] = 1'b0;
        m_smp = (nxt < HI);
        pos = nxt;
    endtask

    task automatic compare(input int c);
        check("R1 smp_clk", smp_clk, m_smp);
        check("R2/R3/R8/R10 oe_n", oe_n, m_oe);
        check("R5/R9 frame_valid", fvalid, m_valid);
        for (int k = 0; k < NCH; k++)
            check("R4/R6 frame field", frame[k*DW +: DW], m_frame[k]);
        if (fvalid)  // R4: published words are the granted converters' words
            for (int k = 0; k < NCH; k++)
                check("R4 word value", frame[k*DW +: DW], word_of(k, c / DIV));
    endtask

    initial begin
        bit e_s;
        int b_s;
        logic [NCH-1:0] oe_s;
        rst_n = 1'b0; en = 1'b1; bus = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 oe_n", oe_n, {NCH{1'b1}});
        check("R7 frame_valid", fvalid, 0);
        check("R7 frame", frame == '0, 1);
        check("R7 smp_clk", smp_clk, 1);
        @(posedge clk);
        #1 rst_n = 1'b1; en = en_for(0); bus = DW'($urandom);
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            compare(c);
            e_s = en; b_s = int'(bus); oe_s = oe_n;
            @(posedge clk);
            model_step(e_s, b_s);
            #1;
            en = en_for(c + 1);
            bus = DW'($urandom);
            for (int k = 0; k < NCH; k++)
                if (!oe_s[k]) bus = DW'(word_of(k, c / DIV));
        end
        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (NCYC + 2000) @(posedge clk);
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule